// File: doc/BRIEF.md
# Lockable Software Reset Controller

This block gives software control over a vector of active-low peripheral reset outputs. Each output has two register bits. The first is a control bit: writing 0 requests a reset and writing 1 releases it. The second is a lock bit that decides whether the control bit still accepts writes. Software opens a window in which it can pulse individual peripheral resets. It then clears lock bits to freeze chosen outputs for good, until the next hardware reset.

Each output is also gated by a per-output active-low hardware reset input. That input always wins over the software request. The gated value is registered, so every output comes straight from a flip-flop and cannot glitch. A small register port with a one-bit select gives write and read access to the lock vector and the control vector. Reads have one cycle of latency.

Top module: `swrst_lock_ctrl`

## Requirements
- R1: While `rst` is high, every `periph_rst_no` bit is 0. After reset, the lock vector and the control vector both read as all ones.
- R2: Writing 0 to a control bit (`wr_sel`=1) whose lock bit is 1 drives that output low. The output changes at the second rising edge after the write edge, counting the write edge as the first.
- R3: Writing 1 to an unlocked control bit releases that output (if its hardware reset is inactive) with the same two-edge latency as R2.
- R4: A write to the lock vector (`wr_sel`=0) clears each lock bit whose data bit is 0. Data bits of 1 leave lock bits unchanged, so a cleared lock bit stays 0 until `rst`.
- R5: A control bit whose lock bit is 0 keeps its value whatever is written to it. Its output does not change.
- R6: When `hw_rst_ni[i]` is 0 at a rising edge, `periph_rst_no[i]` is 0 after that edge, whatever the control bit holds.
- R7: Outside reset, after each edge `periph_rst_no` equals the AND of `hw_rst_ni` and the control vector sampled at that edge. Outputs therefore release cleanly once both are 1, even when a hardware reset arrives together with a control write.
- R8: `rd_data` returns, one edge after `rd_sel` is sampled, the lock vector for `rd_sel`=0 and the control vector for `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 lock vector, 1 control vector |
| wr_data | input | N | Write data |
| rd_sel | input | 1 | Read target: 0 lock vector, 1 control vector |
| rd_data | output | N | Registered read data |
| hw_rst_ni | input | N | Per-output hardware reset, active low |
| periph_rst_no | output | N | Peripheral reset outputs, active low |

## Verification
Four properties are checked on every cycle: lock bits only ever fall, locked control bits never move, an active hardware reset forces its output low on the next edge, and unlocked control bits take the written data. Two things can only be shown by the bench's scenarios. The first is the exact two-edge write-to-output latency across every combination of lock pattern and written data on a four-output configuration. The second is the register read-back and the clean release after a hardware reset that coincides with a control write.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  typedef enum logic {
    SEL_LOCK = 1'b0,
    SEL_CTRL = 1'b1
  } swrst_sel_e;
endpackage

// File: rtl/swrst_lock_bank.sv
module swrst_lock_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] lock_q
);
  // Write-zero-to-clear: a 1 in the data leaves the bit alone.
  always_ff @(posedge clk) begin
    if (rst)     lock_q <= '1;
    else if (we) lock_q <= lock_q & wdata;
  end
endmodule

// File: rtl/swrst_ctrl_bank.sv
module swrst_ctrl_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] lock,
  output logic [N-1:0] ctrl_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                 ctrl_q[i] <= 1'b1;
      else if (we && lock[i])  ctrl_q[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/swrst_out_stage.sv
module swrst_out_stage #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_rst_ni,
  input  logic [N-1:0] ctrl,
  output logic [N-1:0] rst_no
);
  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) rst_no[i] <= 1'b0;
      else     rst_no[i] <= hw_rst_ni[i] & ctrl[i];
    end
  end
endmodule

// File: rtl/swrst_lock_ctrl.sv
module swrst_lock_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [N-1:0] wr_data,
  input  logic         rd_sel,
  output logic [N-1:0] rd_data,
  input  logic [N-1:0] hw_rst_ni,
  output logic [N-1:0] periph_rst_no
);
  import swrst_pkg::*;

  logic [N-1:0] lock_q;
  logic [N-1:0] ctrl_q;
  swrst_sel_e   wsel;
  swrst_sel_e   rsel;

  assign wsel = swrst_sel_e'(wr_sel);
  assign rsel = swrst_sel_e'(rd_sel);

  swrst_lock_bank #(.N(N)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en && wsel == SEL_LOCK),
    .wdata  (wr_data),
    .lock_q (lock_q)
  );

  swrst_ctrl_bank #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en && wsel == SEL_CTRL),
    .wdata  (wr_data),
    .lock   (lock_q),
    .ctrl_q (ctrl_q)
  );

  swrst_out_stage #(.N(N)) u_out (
    .clk       (clk),
    .rst       (rst),
    .hw_rst_ni (hw_rst_ni),
    .ctrl      (ctrl_q),
    .rst_no    (periph_rst_no)
  );

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= '0;
    else if (rsel == SEL_CTRL)  rd_data <= ctrl_q;
    else                        rd_data <= lock_q;
  end
endmodule

// File: rtl/swrst_lock_ctrl_chk.sv
module swrst_lock_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] hw_rst_ni,
  input logic [N-1:0] periph_rst_no,
  input logic [N-1:0] lock_q,
  input logic [N-1:0] ctrl_q
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (periph_rst_no == '0 && lock_q == '1 && ctrl_q == '1)); // R1

  AST_UNLOCKED_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (((ctrl_q ^ $past(wr_data)) & $past(lock_q)) == '0)); // R2

  AST_LOCK_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lock_q & ~$past(lock_q)) == '0)); // R4

  AST_LOCKED_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((ctrl_q ^ $past(ctrl_q)) & ~$past(lock_q)) == '0)); // R5

  AST_HW_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    (hw_rst_ni != '1) |=> ((periph_rst_no & ~$past(hw_rst_ni)) == '0)); // R6
endmodule

bind swrst_lock_ctrl swrst_lock_ctrl_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .wr_data       (wr_data),
  .hw_rst_ni     (hw_rst_ni),
  .periph_rst_no (periph_rst_no),
  .lock_q        (lock_q),
  .ctrl_q        (ctrl_q)
);

// File: tb/swrst_lock_ctrl_bench.sv
`timescale 1ns/1ps
module swrst_lock_ctrl_bench;
  localparam int NB = 4;
  localparam int NV = 1 << NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [NB-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [NB-1:0] rd_data;
  logic [NB-1:0] hw_rst_ni = '1;
  logic [NB-1:0] periph_rst_no;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swrst_lock_ctrl #(.N(NB)) u_swrst_lock_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .hw_rst_ni(hw_rst_ni),
    .periph_rst_no(periph_rst_no)
  );

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; hw_rst_ni = '1;
    @(posedge clk); @(negedge clk);
    check("R1", periph_rst_no, '0);
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [NB-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [NB-1:0] v);
    @(negedge clk); rd_sel = sel;
    @(posedge clk); @(negedge clk); v = rd_data;
  endtask

  initial begin
    logic [NB-1:0] v;
    logic [NB-1:0] lk;
    logic [NB-1:0] p0;
    logic [NB-1:0] ct;
    do_reset();
    rd(1'b0, v); check("R1 lock", v, '1);
    rd(1'b1, v); check("R1 ctrl", v, '1);
    check("R1 out", periph_rst_no, '1);

    // R2/R3/R4/R5/R8: every lock pattern against every written value
    for (int l = 0; l < NV; l++) begin
      do_reset();
      lk = l[NB-1:0];
      p0 = lk ^ 4'b1010;
      wr(1'b1, p0);
      wr(1'b0, lk);
      wr(1'b0, '1);              // R4: ones do not re-open
      rd(1'b0, v); check("R4 lock", v, lk);
      ct = p0;
      for (int w = 0; w < NV; w++) begin
        wr(1'b1, w[NB-1:0]);
        ct = (w[NB-1:0] & lk) | (ct & ~lk);
        // write edge then one more edge to the output
        @(posedge clk); @(negedge clk);
        check("R2 R3 R5 out", periph_rst_no, ct);
        rd(1'b1, v); check("R8 R5 ctrl", v, ct);
      end
    end

    // R6/R7: hardware reset patterns over a known control value
    do_reset();
    wr(1'b1, 4'b0110);
    for (int h = 0; h < NV; h++) begin
      @(negedge clk); hw_rst_ni = h[NB-1:0];
      @(posedge clk); @(negedge clk);
      check("R6 R7 hw", periph_rst_no, h[NB-1:0] & 4'b0110);
    end

    // R7: hardware reset coinciding with a control write, then release
    @(negedge clk); hw_rst_ni = '0; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b1101;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    check("R7 race low", periph_rst_no, '0);
    hw_rst_ni = '1;
    @(posedge clk); @(negedge clk);
    check("R7 race release", periph_rst_no, 4'b1101);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule